// File: doc/BRIEF.md
# Buffer Occupancy Throttle Controller

This block watches the fill counts of four data buffers and produces the flow-control signals that go back toward the trigger source and the data senders. A `warn` output asks the trigger source to lower its rate. A `busy` output asks it to stop triggering altogether. A `stop` output tells the upstream senders to stop pushing data while `busy` is set. Each request latches once raised and drops only at a lower level, so the outputs do not toggle when a count wanders around a threshold.

The warning level is a fixed fraction of the buffer depth. The busy level depends on the room left for one event of the largest allowed size. One buffer past a level is enough to raise a request. Every buffer must have drained below the matching release level before that request drops. All outputs come from registers and follow an occupancy change by one clock. The parameters must satisfy `2*MAX_EVT < DEPTH`, so that the busy raise level sits above the busy release level.

Top module: `throttle_ctrl`

## Requirements
- R1: While reset is held, and after it is released with all counts at zero, `warn_o`, `busy_o` and `stop_o` are 0.
- R2: When any buffer count is at least 3*DEPTH/4 (768 at the default DEPTH of 1024), `warn_o` is 1 on the next clock. A count of 767 alone does not raise it.
- R3: Once raised, `warn_o` stays 1 until every buffer count is at most DEPTH/16 (64 by default). It is 0 on the clock after that holds, provided busy is not raised. A count of 65 in any buffer keeps it at 1.
- R4: When the free room of any buffer (DEPTH minus count) is at most MAX_EVT, meaning a count of at least 896 with the defaults, `busy_o` is 1 on the next clock. A count of 895 alone does not raise it.
- R5: Once raised, `busy_o` stays 1 until every buffer count is at most DEPTH/2 (512 by default). It is 0 on the clock after that holds. A count of 513 in any buffer keeps it at 1.
- R6: `stop_o` equals `busy_o` on every clock.
- R7: `warn_o` is 1 whenever `busy_o` is 1, and it stays 1 when busy releases while some count is still above DEPTH/16.
- R8: Each of the four buffers, with the others empty, can raise and hold both requests on its own. Buffer b occupies bits [b*OCC_W +: OCC_W] of `occ_i`, where OCC_W = clog2(DEPTH+1), which is 11 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| occ_i | input | NUM_BUF*OCC_W | Packed occupancy counts, buffer b at bits [b*OCC_W +: OCC_W] |
| warn_o | output | 1 | Rate-reduction request |
| busy_o | output | 1 | Trigger-stop request |
| stop_o | output | 1 | Stop request to upstream data senders |

## Verification
The assertions check the following on every clock:
- A raise condition always leads to the request on the next clock.
- A latched request never drops while its release condition is false.
- Every rise and every fall has a cause in the previous cycle.
- Stop matches busy, and warning covers busy.

The exact threshold values can only be shown by the bench's scenarios, which step a count to one below and exactly onto each level. The scenarios also check that each buffer index is decoded from its own bit field. They show the combined sequence in which busy releases at half depth while warning is held until the counts fall to one-sixteenth.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

  // Per-buffer level comparison results
  typedef struct packed {
    logic warn_hit;   // count at or above warning level
    logic warn_low;   // count at or below warning release level
    logic busy_hit;   // free room at or below one max event
    logic busy_low;   // count at or below busy release level
  } lvl_flags_t;

  function automatic int unsigned depth_frac(int unsigned depth,
                                             int unsigned num,
                                             int unsigned den);
    return (depth * num) / den;
  endfunction

endpackage

// File: rtl/occ_level_cmp.sv
module occ_level_cmp
  import throttle_pkg::*;
#(
  parameter int unsigned OCC_W    = 11,
  parameter int unsigned WARN_ON  = 768,
  parameter int unsigned WARN_OFF = 64,
  parameter int unsigned BUSY_ON  = 896,
  parameter int unsigned BUSY_OFF = 512
) (
  input  logic [OCC_W-1:0] occ_i,
  output lvl_flags_t       flags_o
);

  localparam logic [OCC_W-1:0] WarnOn  = OCC_W'(WARN_ON);
  localparam logic [OCC_W-1:0] WarnOff = OCC_W'(WARN_OFF);
  localparam logic [OCC_W-1:0] BusyOn  = OCC_W'(BUSY_ON);
  localparam logic [OCC_W-1:0] BusyOff = OCC_W'(BUSY_OFF);

  always_comb begin
    flags_o.warn_hit = (occ_i >= WarnOn);
    flags_o.warn_low = (occ_i <= WarnOff);
    flags_o.busy_hit = (occ_i >= BusyOn);
    flags_o.busy_low = (occ_i <= BusyOff);
  end

endmodule

// File: rtl/hyst_latch.sv
module hyst_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic force_i,
  output logic nxt_o,
  output logic q_o
);

  logic q_d;
  logic q_q;

  // Raise or force wins over release; otherwise hold until release
  always_comb begin
    q_d = q_q;
    if (set_i || force_i) begin
      q_d = 1'b1;
    end else if (clr_i) begin
      q_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= 1'b0;
    end else begin
      q_q <= q_d;
    end
  end

  assign nxt_o = q_d;
  assign q_o   = q_q;

  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || force_i) |=> q_o); // R2 R4
  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o); // R3 R5
  AST_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_o) |-> $past(set_i || force_i)); // R2 R4
  AST_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(q_o) |-> $past(clr_i && !set_i && !force_i)); // R3 R5

endmodule

// File: rtl/throttle_ctrl.sv
module throttle_ctrl
  import throttle_pkg::*;
#(
  parameter int unsigned NUM_BUF = 4,
  parameter int unsigned DEPTH   = 1024,
  parameter int unsigned MAX_EVT = 128,   // requires 2*MAX_EVT < DEPTH
  localparam int unsigned OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_BUF*OCC_W-1:0] occ_i,
  output logic                     warn_o,
  output logic                     busy_o,
  output logic                     stop_o
);

  localparam int unsigned WarnOn  = depth_frac(DEPTH, 3, 4);
  localparam int unsigned WarnOff = depth_frac(DEPTH, 1, 16);
  localparam int unsigned BusyOn  = DEPTH - MAX_EVT;
  localparam int unsigned BusyOff = depth_frac(DEPTH, 1, 2);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[1];

  // Per-buffer compares
  lvl_flags_t flags [NUM_BUF];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_cmp
    occ_level_cmp #(
      .OCC_W   (OCC_W),
      .WARN_ON (WarnOn),
      .WARN_OFF(WarnOff),
      .BUSY_ON (BusyOn),
      .BUSY_OFF(BusyOff)
    ) i_cmp (
      .occ_i  (occ_i[g*OCC_W +: OCC_W]),
      .flags_o(flags[g])
    );
  end

  // Reduce: any buffer raises, all buffers must release
  logic warn_any_hit;
  logic warn_all_low;
  logic busy_any_hit;
  logic busy_all_low;

  always_comb begin
    warn_any_hit = 1'b0;
    warn_all_low = 1'b1;
    busy_any_hit = 1'b0;
    busy_all_low = 1'b1;
    for (int b = 0; b < NUM_BUF; b++) begin
      warn_any_hit = warn_any_hit | flags[b].warn_hit;
      warn_all_low = warn_all_low & flags[b].warn_low;
      busy_any_hit = busy_any_hit | flags[b].busy_hit;
      busy_all_low = busy_all_low & flags[b].busy_low;
    end
  end

  // Busy latch, then warning latch forced by busy
  logic busy_nxt;
  logic warn_nxt;
  logic busy_q;
  logic warn_q;

  hyst_latch i_busy (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .set_i  (busy_any_hit),
    .clr_i  (busy_all_low),
    .force_i(1'b0),
    .nxt_o  (busy_nxt),
    .q_o    (busy_q)
  );

  hyst_latch i_warn (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .set_i  (warn_any_hit),
    .clr_i  (warn_all_low),
    .force_i(busy_nxt),
    .nxt_o  (warn_nxt),
    .q_o    (warn_q)
  );

  // Upstream stop: its own register, fed from the busy next state
  logic stop_d;
  logic stop_q;

  always_comb begin
    stop_d = busy_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
    end else begin
      stop_q <= stop_d;
    end
  end

  assign warn_o = warn_q;
  assign busy_o = busy_q;
  assign stop_o = stop_q;

  AST_STOP_FOLLOWS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n)
    stop_o == busy_o); // R6
  AST_BUSY_IMPLIES_WARN: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy_o |-> warn_o); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n |-> (!warn_o && !busy_o && !stop_o)); // R1
  AST_WARN_UNUSED_NXT: assert property (@(posedge clk_i) disable iff (!rst_n)
    warn_nxt |=> warn_o); // R3

endmodule

// File: tb/test_throttle_ctrl.sv
`timescale 1ns/1ps
module test_throttle_ctrl;

  localparam int unsigned NUM_BUF = 4;
  localparam int unsigned DEPTH   = 1024;
  localparam int unsigned MAX_EVT = 128;
  localparam int unsigned OCC_W   = $clog2(DEPTH + 1);

  localparam int unsigned W_ON  = DEPTH * 3 / 4;
  localparam int unsigned W_OFF = DEPTH / 16;
  localparam int unsigned B_ON  = DEPTH - MAX_EVT;
  localparam int unsigned B_OFF = DEPTH / 2;

  logic                     clk_i = 1'b0;
  logic                     rst_ni;
  logic [NUM_BUF*OCC_W-1:0] occ_i;
  logic                     warn_o;
  logic                     busy_o;
  logic                     stop_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  throttle_ctrl #(
    .NUM_BUF(NUM_BUF),
    .DEPTH  (DEPTH),
    .MAX_EVT(MAX_EVT)
  ) i_throttle_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .occ_i (occ_i),
    .warn_o(warn_o),
    .busy_o(busy_o),
    .stop_o(stop_o)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(string req, logic w, logic b);
    chk(req, "warn", warn_o, w);
    chk(req, "busy", busy_o, b);
    chk("R6", "stop", stop_o, b);
  endtask

  // Drive on the falling edge; the next falling edge sees the registered result
  task automatic set_occ(int b, int unsigned v);
    occ_i[b*OCC_W +: OCC_W] = OCC_W'(v);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    occ_i  = '0;
    repeat (3) @(negedge clk_i);
    chk_all("R1", 1'b0, 1'b0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk_all("R1", 1'b0, 1'b0);
  endtask

  task automatic t_warn_each();
    for (int b = 0; b < NUM_BUF; b++) begin
      set_occ(b, W_ON - 1);
      chk_all("R2", 1'b0, 1'b0);
      set_occ(b, W_ON);
      chk_all("R8", 1'b1, 1'b0);
      set_occ(b, W_OFF + 1);
      chk_all("R3", 1'b1, 1'b0);
      set_occ(b, W_OFF);
      chk_all("R3", 1'b0, 1'b0);
      set_occ(b, 0);
    end
  endtask

  task automatic t_warn_multi();
    set_occ(0, 800);
    set_occ(1, 800);
    chk_all("R2", 1'b1, 1'b0);
    set_occ(0, 0);
    chk_all("R3", 1'b1, 1'b0);
    set_occ(1, W_OFF);
    chk_all("R3", 1'b0, 1'b0);
    set_occ(1, 0);
  endtask

  task automatic t_busy_levels();
    set_occ(2, B_ON - 1);
    chk_all("R4", 1'b1, 1'b0);
    set_occ(2, B_ON);
    chk_all("R4", 1'b1, 1'b1);
    set_occ(2, B_OFF + 1);
    chk_all("R5", 1'b1, 1'b1);
    set_occ(2, B_OFF);
    chk_all("R7", 1'b1, 1'b0);
    set_occ(2, W_OFF);
    chk_all("R3", 1'b0, 1'b0);
    set_occ(2, 0);
  endtask

  task automatic t_busy_each();
    for (int b = 0; b < NUM_BUF; b++) begin
      set_occ(b, DEPTH);
      chk_all("R8", 1'b1, 1'b1);
      set_occ(b, B_OFF + 1);
      chk_all("R5", 1'b1, 1'b1);
      set_occ(b, 0);
      chk_all("R5", 1'b0, 1'b0);
    end
  endtask

  task automatic t_busy_multi();
    set_occ(0, 900);
    set_occ(3, 900);
    chk_all("R4", 1'b1, 1'b1);
    set_occ(0, 0);
    chk_all("R5", 1'b1, 1'b1);
    set_occ(3, B_OFF);
    chk_all("R7", 1'b1, 1'b0);
    set_occ(3, 0);
    chk_all("R3", 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_warn_each();
    t_warn_multi();
    t_busy_levels();
    t_busy_each();
    t_busy_multi();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule